// File: doc/BRIEF.md
# Run-Time Accuracy-Selectable Pipelined Adder

This block adds two 32-bit operands through a four-stage pipeline in which accuracy can be traded against switching activity at run time. The first stage splits the operands into four 8-bit segments and adds each segment on its own, with a carry-in of zero. Only the lowest segment is exact at that point. Each later stage repairs one more segment, from low to high. It does this by adding in the true carry that arrives from the corrected segment below.

A 2-bit mode code sets how many stages are clocked. Stages beyond the last enabled one hold their registers, which stands in for power gating. The output is taken from the register of the last enabled stage. So the latency in cycles equals the number of enabled stages, and the number of exact low segments equals the same count. A new code takes hold only after the pipeline has drained. Any input offered while the requested code differs from the active one is dropped.

Top module: `apx_cfg_adder`

## Requirements
- R1: While rst_n is low and in the first cycle after release, out_valid is 0 and result is 0.
- R2: Mode code 0 enables all four stages. A result appears 4 cycles after its input is accepted, and result equals the exact 33-bit sum a+b.
- R3: Mode code 3 enables stage 1 only and has a latency of 1. Each 8-bit segment i (bits 8i+7..8i) of result is (a_i+b_i) mod 256 with no carry-in, so segment 0 is exact.
- R4: Mode code 2 has a latency of 2. Result bits 15..0 are exact, and segments 2 and 3 are each their own carry-free sums.
- R5: Mode code 1 has a latency of 3. Result bits 23..0 are exact, and segment 3 is its own carry-free sum.
- R6: Result bit 32 is the true carry out of a+b only under code 0. Under the other codes it is the carry out of a_3+b_3 alone.
- R7: A new mode code becomes active only when no stage holds valid data. While the mode input differs from the active code, in_valid is ignored and no result is produced for it.
- R8: Inputs accepted on consecutive cycles give results on consecutive cycles, in the same order.
- R9: Under code 3, out_valid is high exactly in the cycle after an accepted input and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands a and b are offered this cycle |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| mode | input | 2 | Requested accuracy code, 0 = all stages to 3 = first stage only |
| out_valid | output | 1 | result holds a finished sum |
| result | output | 33 | Sum, bit 32 being the carry out |

## Verification
A carry repaired in the wrong stage, or lost between stages, shows up as a segment that is off by one. It appears in the first result whose lower segment overflowed, under any code that covers that segment. A stage enable that is set one stage too wide or too narrow moves the out_valid pulse by a cycle. It also shifts the boundary between exact and approximate segments, so the very first transaction under each code exposes it. Premature switching of the active code would either produce an extra result for a rejected input or cut off a result still in flight. The change scenario checks both within a dozen cycles.

// File: rtl/apx_pkg.sv
package apx_pkg;
   parameter int unsigned DEF_SEG_W   = 8;
   parameter int unsigned DEF_NUM_SEG = 4;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/apx_spec_stage.sv
module apx_spec_stage #(
   parameter int unsigned SEG_W   = apx_pkg::DEF_SEG_W,
   parameter int unsigned NUM_SEG = apx_pkg::DEF_NUM_SEG,
   localparam int unsigned WIDTH  = SEG_W * NUM_SEG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               i_vld,
   input  logic [WIDTH-1:0]   i_a,
   input  logic [WIDTH-1:0]   i_b,
   output logic               o_vld,
   output logic [WIDTH-1:0]   o_sum,
   output logic [NUM_SEG-1:0] o_gen,
   output logic               o_cry
);
   logic [WIDTH-1:0]   loc_sum;
   logic [NUM_SEG-1:0] loc_gen;

   // each segment added on its own, carry-in zero
   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic [SEG_W:0] part;
      assign part = {1'b0, i_a[s*SEG_W +: SEG_W]} + {1'b0, i_b[s*SEG_W +: SEG_W]};
      assign loc_sum[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
      assign loc_gen[s] = part[SEG_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_vld <= 1'b0;
         o_sum <= '0;
         o_gen <= '0;
         o_cry <= 1'b0;
      end else if (en) begin
         o_vld <= i_vld;
         o_sum <= loc_sum;
         o_gen <= loc_gen;
         o_cry <= loc_gen[0];   // segment 0 is exact: its carry is the true one
      end
   end
endmodule

// File: rtl/apx_fix_stage.sv
module apx_fix_stage #(
   parameter int unsigned SEG_W   = apx_pkg::DEF_SEG_W,
   parameter int unsigned NUM_SEG = apx_pkg::DEF_NUM_SEG,
   parameter int unsigned IDX     = 1,
   localparam int unsigned WIDTH  = SEG_W * NUM_SEG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               i_vld,
   input  logic [WIDTH-1:0]   i_sum,
   input  logic [NUM_SEG-1:0] i_gen,
   input  logic               i_cry,
   output logic               o_vld,
   output logic [WIDTH-1:0]   o_sum,
   output logic [NUM_SEG-1:0] o_gen,
   output logic               o_cry
);
   logic [SEG_W:0]   bumped;
   logic [WIDTH-1:0] nxt_sum;
   logic             nxt_cry;

   // add the true carry from below; carry out is the segment's own
   // generate or an overflow of the increment
   assign bumped  = {1'b0, i_sum[IDX*SEG_W +: SEG_W]} + (SEG_W+1)'(i_cry);
   assign nxt_cry = i_gen[IDX] | bumped[SEG_W];

   always_comb begin
      nxt_sum = i_sum;
      nxt_sum[IDX*SEG_W +: SEG_W] = bumped[SEG_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_vld <= 1'b0;
         o_sum <= '0;
         o_gen <= '0;
         o_cry <= 1'b0;
      end else if (en) begin
         o_vld <= i_vld;
         o_sum <= nxt_sum;
         o_gen <= i_gen;
         o_cry <= nxt_cry;
      end
   end
endmodule

// File: rtl/apx_cfg_adder.sv
module apx_cfg_adder #(
   parameter int unsigned SEG_W   = apx_pkg::DEF_SEG_W,
   parameter int unsigned NUM_SEG = apx_pkg::DEF_NUM_SEG,
   localparam int unsigned WIDTH  = SEG_W * NUM_SEG,
   localparam int unsigned MODE_W = $clog2(NUM_SEG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WIDTH-1:0]  a,
   input  logic [WIDTH-1:0]  b,
   input  logic [MODE_W-1:0] mode,
   output logic              out_valid,
   output logic [WIDTH:0]    result
);
   if (NUM_SEG < 2 || !apx_pkg::is_pow2(NUM_SEG)) begin : g_bad_seg
      $error("NUM_SEG must be a power of two, at least 2");
   end
   if (SEG_W < 1) begin : g_bad_w
      $error("SEG_W must be at least 1");
   end

   localparam logic [MODE_W-1:0] LAST = MODE_W'(NUM_SEG - 1);

   logic [MODE_W-1:0]  act_mode;
   logic [MODE_W-1:0]  last_idx;
   logic               take;
   logic               busy;
   logic [NUM_SEG-1:0] st_en;
   logic [NUM_SEG-1:0] st_vld;
   logic [NUM_SEG-1:0] st_cry;
   logic [WIDTH-1:0]   st_sum [NUM_SEG];
   logic [NUM_SEG-1:0] st_gen [NUM_SEG];

   assign last_idx = LAST - act_mode;
   assign take     = in_valid && (mode == act_mode);
   assign busy     = |st_vld;

   always_comb begin
      for (int k = 0; k < NUM_SEG; k++) begin
         st_en[k] = (MODE_W'(k) <= last_idx);
      end
   end

   // mode switch only once every stage has drained
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_mode <= '0;
      end else if (!busy && (mode != act_mode)) begin
         act_mode <= mode;
      end
   end

   apx_spec_stage #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_spec (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (st_en[0]),
      .i_vld (take),
      .i_a   (a),
      .i_b   (b),
      .o_vld (st_vld[0]),
      .o_sum (st_sum[0]),
      .o_gen (st_gen[0]),
      .o_cry (st_cry[0])
   );

   for (genvar k = 1; k < NUM_SEG; k++) begin : g_fix
      apx_fix_stage #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .IDX(k)) u_fix (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (st_en[k]),
         .i_vld (st_vld[k-1]),
         .i_sum (st_sum[k-1]),
         .i_gen (st_gen[k-1]),
         .i_cry (st_cry[k-1]),
         .o_vld (st_vld[k]),
         .o_sum (st_sum[k]),
         .o_gen (st_gen[k]),
         .o_cry (st_cry[k])
      );
   end

   // top bit: true carry once the top segment is repaired, else its local carry
   assign out_valid = st_vld[last_idx];
   assign result    = {(last_idx == LAST) ? st_cry[last_idx] : st_gen[last_idx][NUM_SEG-1],
                       st_sum[last_idx]};
endmodule

module apx_cfg_adder_chk #(
   parameter int unsigned SEG_W  = 8,
   parameter int unsigned MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              take,
   input logic [MODE_W-1:0] act_mode,
   input logic              out_valid,
   input logic [SEG_W-1:0]  a_lo,
   input logic [SEG_W-1:0]  b_lo,
   input logic [SEG_W-1:0]  res_lo
);
   // R3
   one_stage_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && act_mode == '1) |=> out_valid);
   // R3
   one_stage_seg0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && act_mode == '1) |=> (res_lo == $past(SEG_W'(a_lo + b_lo))));
   // R9
   one_stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && act_mode == '1) |=> !out_valid);
   // R7
   mode_swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(act_mode) |-> $past(!out_valid));
endmodule

bind apx_cfg_adder apx_cfg_adder_chk #(.SEG_W(SEG_W), .MODE_W(MODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .take      (take),
   .act_mode  (act_mode),
   .out_valid (out_valid),
   .a_lo      (a[SEG_W-1:0]),
   .b_lo      (b[SEG_W-1:0]),
   .res_lo    (result[SEG_W-1:0])
);

// File: tb/test_apx_cfg_adder.sv
module test_apx_cfg_adder;
   localparam int CLK_PERIOD = 10;
   localparam int SEG_W      = 8;
   localparam int NUM_SEG    = 4;
   localparam int WIDTH      = SEG_W * NUM_SEG;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [WIDTH-1:0] a = '0;
   logic [WIDTH-1:0] b = '0;
   logic [1:0]       mode = 2'd0;
   logic             out_valid;
   logic [WIDTH:0]   result;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   apx_cfg_adder i_apx_cfg_adder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
      .mode(mode), .out_valid(out_valid), .result(result)
   );

   task automatic chk(bit ok, string req, logic [WIDTH:0] act, logic [WIDTH:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // n lowest segments exact, rest carry-free; bit 32 true only when n==NUM_SEG
   function automatic logic [WIDTH:0] model(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, int n);
      logic [WIDTH:0] r = '0;
      logic           c = 1'b0;
      logic [SEG_W:0] t;
      logic           loc_top = 1'b0;
      for (int i = 0; i < NUM_SEG; i++) begin
         t = {1'b0, x[i*SEG_W +: SEG_W]} + {1'b0, y[i*SEG_W +: SEG_W]};
         if (i == NUM_SEG-1) loc_top = t[SEG_W];
         if (i < n) begin
            t = t + (SEG_W+1)'(c);
            c = t[SEG_W];
         end
         r[i*SEG_W +: SEG_W] = t[SEG_W-1:0];
      end
      r[WIDTH] = (n == NUM_SEG) ? c : loc_top;
      return r;
   endfunction

   task automatic set_mode(logic [1:0] m);
      @(negedge clk);
      in_valid = 1'b0;
      mode = m;
      repeat (8) @(negedge clk);
   endtask

   task automatic one_op(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, int n, string req);
      int cnt;
      a = x; b = y; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      cnt = 1;
      while (!out_valid && cnt < 10) begin
         @(negedge clk);
         cnt++;
      end
      chk(cnt == n, {req, " latency"}, (WIDTH+1)'(cnt), (WIDTH+1)'(n));
      chk(result == model(x, y, n), {req, " value"}, result, model(x, y, n));
      @(negedge clk);
   endtask

   task automatic run_set(logic [1:0] m, string req);
      int n = NUM_SEG - int'(m);
      set_mode(m);
      one_op(32'hFFFF_FFFF, 32'h0000_0001, n, req);
      one_op(32'h8000_0000, 32'h8000_0000, n, req);
      one_op(32'h1234_5678, 32'h9ABC_DEF0, n, req);
      one_op(32'h00FF_00FF, 32'h0001_0001, n, req);
      one_op(32'h7FFF_80FF, 32'h0000_7F01, n, req);
      one_op(32'h0000_0000, 32'h0000_0000, n, req);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      in_valid = 1'b1; a = 32'hFFFF_FFFF; b = 32'h1;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid in reset", (WIDTH+1)'(out_valid), '0);
      chk(result == '0, "R1 result in reset", result, '0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid after release", (WIDTH+1)'(out_valid), '0);
      chk(result == '0, "R1 result after release", result, '0);
   endtask

   task automatic t_top_bit();
      logic [WIDTH:0] e;
      set_mode(2'd0);
      one_op(32'hFFFF_FFFF, 32'h0000_0001, 4, "R6 full");
      e = 33'h1_0000_0000;
      chk(model(32'hFFFF_FFFF, 32'h1, 4) == e, "R6 exact carry", model(32'hFFFF_FFFF, 32'h1, 4), e);
      set_mode(2'd1);
      one_op(32'hFFFF_FFFF, 32'h0000_0001, 3, "R6 code1");
      chk(result[WIDTH] == 1'b0, "R6 local top carry", (WIDTH+1)'(result[WIDTH]), '0);
   endtask

   task automatic t_one_idle();
      set_mode(2'd3);
      one_op(32'h0000_00FF, 32'h0000_0001, 1, "R9");
      chk(out_valid == 1'b0, "R9 no output without input", (WIDTH+1)'(out_valid), '0);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R9 idle", (WIDTH+1)'(out_valid), '0);
   endtask

   task automatic t_stream();
      logic [WIDTH-1:0] xs [6];
      logic [WIDTH-1:0] ys [6];
      for (int i = 0; i < 6; i++) begin
         xs[i] = 32'h0F0F_F0F0 * (i + 3) + 32'hFF;
         ys[i] = 32'h1111_0F11 * (i + 1);
      end
      set_mode(2'd0);
      for (int j = 0; j <= 10; j++) begin
         if (j >= 4 && j < 10) begin
            chk(out_valid == 1'b1, "R8 back-to-back valid", (WIDTH+1)'(out_valid), 1);
            chk(result == model(xs[j-4], ys[j-4], 4), "R8 order", result, model(xs[j-4], ys[j-4], 4));
         end
         if (j == 10)
            chk(out_valid == 1'b0, "R8 stream end", (WIDTH+1)'(out_valid), '0);
         if (j < 6) begin
            a = xs[j]; b = ys[j]; in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic t_change();
      int outs = 0;
      int at = -1;
      logic [WIDTH:0] seen = '0;
      logic [WIDTH-1:0] x1 = 32'h00FF_FFFF, y1 = 32'h0000_0001;
      logic [WIDTH-1:0] x2 = 32'h01FF_FF80, y2 = 32'h0000_0080;
      set_mode(2'd0);
      a = x1; b = y1; in_valid = 1'b1;
      @(negedge clk);
      for (int j = 1; j <= 14; j++) begin
         if (out_valid) begin
            outs++;
            at = j;
            seen = result;
         end
         if (j <= 5) begin
            mode = 2'd3; a = x2; b = y2; in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
      chk(outs == 1, "R7 single result, change input dropped", (WIDTH+1)'(outs), 1);
      chk(at == 4, "R7 in-flight latency kept", (WIDTH+1)'(at), 4);
      chk(seen == model(x1, y1, 4), "R7 in-flight exact", seen, model(x1, y1, 4));
      one_op(x2, y2, 1, "R7 new code active");
   endtask

   initial begin
      t_reset();
      run_set(2'd0, "R2");
      run_set(2'd3, "R3");
      run_set(2'd2, "R4");
      run_set(2'd1, "R5");
      t_top_bit();
      t_one_idle();
      t_stream();
      t_change();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule